// File: doc/BRIEF.md
# Grouped DMA Event Interrupt Register

This block is the interrupt control/status register of a DMA bridge. It sits beside ten event sources. Two of them belong to a USB transfer path: transfer complete and address error. The other eight belong to two stereo audio channels. Each channel has a play direction and a record direction, and each direction reports a full-buffer event and a half-buffer event. Every event arrives as a single-cycle pulse. The register keeps a sticky status bit and an enable bit for each event.

Software reads the whole 32-bit word on a plain read port. It writes back zeros to the status bits it has serviced, and zeros to the enable bits of events it wants masked. Writing a one to a status bit changes nothing. A whole word can therefore be read, modified and written back without acknowledging events by accident.

The ten events are grouped onto three registered, level-sensitive interrupt lines by category:
- USB address error alone.
- Every completion.
- Every half-completion.

Top module: `grp_irq_reg`

## Requirements
- R1: A pulse on `evtPulse[n]` sets the status bit of event n, and `rdData` shows it after the next rising clock edge. The status bit is `rdData[n]` for n = 0..1 and `rdData[n+14]` for n = 2..9. Event 0 is USB transfer complete and event 1 is USB address error.
- R2: A write loads the enable bits from `wrData`, and `rdData` shows them after the write. The enable bit is bit n+8 for n = 0..1 and bit n+22 for n = 2..9.
- R3: A write with a 0 in a status bit position clears that status bit. A write with a 1 in that position leaves the bit unchanged.
- R4: If an event pulse arrives in the same cycle as a write that clears its status bit, the bit stays set.
- R5: A status bit records its event even while its enable bit is clear. A pending event whose enable bit is clear does not raise any interrupt line.
- R6: The lines are grouped as follows:
  - `irq[0]` is high when event 1 is pending and enabled.
  - `irq[1]` is high when any of events 0, 2, 4, 6 or 8 is pending and enabled. These are the completion events; even audio events are full-buffer.
  - `irq[2]` is high when any of events 3, 5, 7 or 9 is pending and enabled. These are the half-buffer events.
- R7: Each interrupt line is registered. It changes one clock cycle after the status or enable state that drives it.
- R8: Bits 15..10 and 7..2 of `rdData` always read as 0, whatever has been written.
- R9: While `rstN` is low, every status bit and enable bit is cleared and all three interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data |
| evtPulse | input | 10 | Event pulses, bit n = event n |
| rdData | output | 32 | Current register contents |
| irq | output | 3 | Interrupt lines: USB error, completions, half-completions |

## Verification
The bench builds the block with its default 32-bit register and all ten events. At this size every event can be swept with its enable both set and cleared. Each pass checks the status bit position, the line the event selects and the one-cycle line latency, and then acknowledges the event. The small event count also puts a simultaneous pulse on all ten events, the event-versus-acknowledge collision and the write-one-keeps case within reach, all with expected bit positions computed arithmetically.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  localparam int USB_EVT   = 2;
  localparam int AUDIO_EVT = 8;
  localparam int NUM_EVT   = USB_EVT + AUDIO_EVT;
  localparam int NUM_LINE  = 3;

  // bit offsets of the fields inside the register word
  localparam int USB_STAT_LO = 0;
  localparam int USB_ENA_LO  = 8;
  localparam int AUD_STAT_LO = 16;
  localparam int AUD_ENA_LO  = 24;

  typedef struct packed {
    logic               load;
    logic [NUM_EVT-1:0] statWr;
    logic [NUM_EVT-1:0] enaWr;
  } ctrlStrb_t;

  function automatic int statPos(input int n);
    return (n < USB_EVT) ? USB_STAT_LO + n : AUD_STAT_LO + n - USB_EVT;
  endfunction

  function automatic int enaPos(input int n);
    return (n < USB_EVT) ? USB_ENA_LO + n : AUD_ENA_LO + n - USB_EVT;
  endfunction

  // 0: USB address error, 1: completions, 2: half-completions
  function automatic int lineOf(input int n);
    if (n == 1) return 0;
    if (n == 0) return 1;
    return (n % 2 == 0) ? 1 : 2;
  endfunction
endpackage

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import grp_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output ctrlStrb_t        strb
);
  logic [NUM_EVT-1:0] statField;
  logic [NUM_EVT-1:0] enaField;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_field
    assign statField[i] = wrData[statPos(i)];
    assign enaField[i]  = wrData[enaPos(i)];
  end

  always_comb begin
    strb.load   = wrEn;
    strb.statWr = statField;
    strb.enaWr  = enaField;
  end
endmodule

// File: rtl/grp_irq_dp.sv
module grp_irq_dp
  import grp_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic [REG_W-1:0]   rdData,
  output logic [NUM_LINE-1:0] irq
);
  logic [NUM_EVT-1:0]  statQ, enaQ, clrMask;
  logic [NUM_LINE-1:0] lineNext, irqQ;

  // a zero written to a status bit acknowledges it
  assign clrMask = strb.load ? ~strb.statWr : '0;

  always_comb begin
    lineNext = '0;
    for (int i = 0; i < NUM_EVT; i++)
      if (statQ[i] && enaQ[i]) lineNext[lineOf(i)] = 1'b1;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      rdData[statPos(i)] = statQ[i];
      rdData[enaPos(i)]  = enaQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= '0;
      enaQ  <= '0;
      irqQ  <= '0;
    end else begin
      statQ <= (statQ & ~clrMask) | evtPulse;
      if (strb.load) enaQ <= strb.enaWr;
      irqQ <= lineNext;
    end
  end

  assign irq = irqQ;
endmodule

// File: rtl/grp_irq_reg.sv
module grp_irq_reg
  import grp_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [REG_W-1:0]    wrData,
  input  logic [NUM_EVT-1:0]  evtPulse,
  output logic [REG_W-1:0]    rdData,
  output logic [NUM_LINE-1:0] irq
);
  ctrlStrb_t strb;

  grp_irq_ctrl #(.REG_W(REG_W)) ctrl_i (
    .wrEn(wrEn), .wrData(wrData), .strb(strb)
  );

  grp_irq_dp #(.REG_W(REG_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .evtPulse(evtPulse),
    .rdData(rdData), .irq(irq)
  );
endmodule

// File: rtl/grp_irq_reg_chk.sv
module grp_irq_reg_chk
  import grp_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [REG_W-1:0]    wrData,
  input logic [NUM_EVT-1:0]  evtPulse,
  input logic [REG_W-1:0]    rdData,
  input logic [NUM_LINE-1:0] irq
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    localparam int SP = statPos(i);
    localparam int EP = enaPos(i);
    // R1
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[i] |=> rdData[SP]);
    // R3
    write_one_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrData[SP] && rdData[SP]) |=> rdData[SP]);
    // R3
    write_zero_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !wrData[SP] && !evtPulse[i]) |=> !rdData[SP]);
    // R2
    ena_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrEn |=> rdData[EP] == $past(wrData[EP]));
  end

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[15:10] == 6'd0 && rdData[7:2] == 6'd0);
  // R6
  usb_err_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irq[0] == $past(rdData[1] & rdData[9]));
  // R7
  half_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irq[2] == $past(|(rdData[23:16] & rdData[31:24] & 8'hAA)));
  // R6
  done_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irq[1] == $past((rdData[0] & rdData[8]) |
                             (|(rdData[23:16] & rdData[31:24] & 8'h55))));
endmodule

bind grp_irq_reg grp_irq_reg_chk #(.REG_W(REG_W)) chk_i (.*);

// File: tb/grp_irq_reg_tb_top.sv
module grp_irq_reg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [9:0]  evtPulse = '0;
  logic [31:0] rdData;
  logic [2:0]  irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [31:0] ALL_STAT = 32'h00FF_0003;

  always #5 clk = ~clk;

  grp_irq_reg dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .evtPulse(evtPulse), .rdData(rdData), .irq(irq)
  );

  function automatic int sPos(input int n);
    return (n < 2) ? n : n + 14;
  endfunction
  function automatic int ePos(input int n);
    return (n < 2) ? n + 8 : n + 22;
  endfunction
  function automatic int lineOf(input int n);
    if (n == 1) return 0;
    if (n == 0 || n % 2 == 0) return 1;
    return 2;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulse(input logic [9:0] e);
    evtPulse = e;
    tick();
    evtPulse = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    evtPulse = 10'h3FF; // events during reset must be dropped
    repeat (3) tick();
    // R9
    chk("R9 reg", rdData, 32'h0);
    chk("R9 irq", {29'd0, irq}, 32'h0);
    evtPulse = '0;
    rstN = 1'b1;
    tick();

    for (int i = 0; i < 10; i++) begin
      for (int en = 0; en < 2; en++) begin
        logic [31:0] enaWord;
        enaWord = en ? (32'h1 << ePos(i)) : 32'h0;
        regWrite(enaWord | ALL_STAT);
        // R2
        chk("R2 enable readback", rdData, enaWord);
        pulse(10'h1 << i);
        // R1 and R5: status recorded whatever the enable
        chk("R1 status set", rdData, enaWord | (32'h1 << sPos(i)));
        tick();
        // R6, R7 (R5 when disabled)
        chk(en ? "R6 line" : "R5 masked", {29'd0, irq},
            en ? (32'h1 << lineOf(i)) : 32'h0);
        regWrite(enaWord | (ALL_STAT & ~(32'h1 << sPos(i))));
        // R3
        chk("R3 ack clears", rdData, enaWord);
        tick();
        chk("R7 line drops", {29'd0, irq}, 32'h0);
      end
    end

    // R6: all events enabled and pending at once
    regWrite(32'hFF00_0300 | ALL_STAT);
    pulse(10'h3FF);
    chk("R6 all status", rdData, 32'hFFFF_0303);
    chk("R7 irq not yet", {29'd0, irq}, 32'h0);
    tick();
    chk("R6 all lines", {29'd0, irq}, 32'h7);
    // R3: write ones keeps status
    regWrite(32'hFFFF_FFFF);
    chk("R3 write one keeps", rdData, 32'hFFFF_0303);
    // R8: reserved bits stay zero
    chk("R8 reserved", rdData & 32'h0000_FCFC, 32'h0);
    // R5: mask all, status stays, lines fall
    regWrite(ALL_STAT);
    chk("R5 masked status", rdData, 32'h00FF_0003);
    tick();
    chk("R5 masked lines", {29'd0, irq}, 32'h0);
    // R4: event collides with acknowledge
    regWrite(32'h0);
    chk("R3 clear all", rdData, 32'h0);
    evtPulse = 10'h020; wrEn = 1'b1; wrData = 32'h0;
    tick();
    evtPulse = '0; wrEn = 1'b0;
    chk("R4 event wins", rdData, 32'h1 << sPos(5));
    // R9: reset mid-run
    regWrite(32'hFF00_0300 | ALL_STAT);
    tick();
    rstN = 1'b0;
    tick();
    chk("R9 reset reg", rdData, 32'h0);
    chk("R9 reset irq", {29'd0, irq}, 32'h0);
    rstN = 1'b1;
    tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule